// File: doc/BRIEF.md
# Rotate Unit with Carry

This block is the rotate stage of a 32-bit processor datapath. Each cycle it takes an operand, an 8-bit rotate count, the current carry flag and a one-bit mode select. From these it produces the rotated value and a carry-out. It also produces a write-enable that tells the flag logic whether the carry-out should replace the carry flag. The input `mode_ext` selects the mode: 0 means rotate right by the given count, and 1 means a one-place rotate right through the carry flag.

Counts above the operand width wrap. A count of zero passes the operand and the incoming carry through unchanged. A nonzero count that is an exact multiple of the width returns the operand and takes the carry from the top bit. The carry write-enable depends on two inputs: the set-flags request and a 4-bit operation-class code that names the instruction consuming the rotated value. All three outputs are registered, so results appear one clock after their inputs.

Top module: `rot_carry_unit`

## Requirements
- R1: All outputs are registered with exactly one cycle of latency. While `rst` is high at a rising edge, `result_q`, `carry_out` and `carry_we` become 0.
- R2: With `mode_ext`=0 and a count whose value modulo 32 is r, where r is 1 to 31, `result_q` is the operand rotated right by r. `carry_out` is operand bit r-1.
- R3: With `mode_ext`=0 and a count of 0, `result_q` equals the operand and `carry_out` equals `carry_in`.
- R4: With `mode_ext`=0 and a count of 32, 64, 96, 128, 160, 192 or 224, `result_q` equals the operand and `carry_out` equals operand bit 31.
- R5: With `mode_ext`=0, any count above 32 gives the same `result_q` and `carry_out` as that count minus 32.
- R6: With `mode_ext`=1, `result_q` is the operand moved right by one place with `carry_in` in bit 31, and `carry_out` is operand bit 0. `amt_in` has no effect in this mode.
- R7: With `set_flags`=1, `carry_we` is 1 exactly when `op_class` is one of these codes: 0 (standalone rotate), 1 move, 2 move-not, 3 AND, 4 OR, 5 OR-not, 6 XOR, 7 bit-clear, 8 test, 9 test-equivalence. Codes 10 to 15 give 0. This rule is the same in both modes.
- R8: With `set_flags`=0, `carry_we` is 0 for every class and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | 32 | Operand to rotate |
| amt_in | input | 8 | Rotate count |
| carry_in | input | 1 | Current carry flag |
| mode_ext | input | 1 | 0 = rotate by count, 1 = extended one-place rotate through carry |
| set_flags | input | 1 | Flag-setting request |
| op_class | input | 4 | Class of the instruction consuming the result |
| result_q | output | 32 | Rotated value (registered) |
| carry_out | output | 1 | Carry produced by the rotate (registered) |
| carry_we | output | 1 | Carry write-back enable (registered) |

## Verification
The bench builds the block with its default parameters: a 32-bit operand and an 8-bit count. With an 8-bit count, every count value from 0 to 255 can be driven. That covers the zero count, all seven nonzero multiples of the width, and every wrapped count. A sweep over all 256 counts on a fixed operand checks the wrap and carry rules against a loop-based model. All 16 class codes are also driven with the set-flags request both high and low.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_ROT  = 4'd0,
    CLS_MOV  = 4'd1,
    CLS_MVN  = 4'd2,
    CLS_AND  = 4'd3,
    CLS_ORR  = 4'd4,
    CLS_ORN  = 4'd5,
    CLS_EOR  = 4'd6,
    CLS_BIC  = 4'd7,
    CLS_TST  = 4'd8,
    CLS_TEQ  = 4'd9,
    CLS_ARITH = 4'd10
  } op_class_e;

  typedef enum logic [1:0] {
    AMT_ZERO = 2'd0,
    AMT_PART = 2'd1,
    AMT_FULL = 2'd2
  } amt_kind_e;
endpackage

// File: rtl/rot_amt_reduce.sv
module rot_amt_reduce #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0]   amt,
  output logic [LOG_W-1:0]   rot_amt,
  output rot_pkg::amt_kind_e kind
);
  logic low_zero;
  logic high_nz;

  assign rot_amt  = amt[LOG_W-1:0];
  assign low_zero = (amt[LOG_W-1:0] == '0);
  assign high_nz  = |amt[AMT_W-1:LOG_W];

  always_comb begin
    if (!low_zero)
      kind = rot_pkg::AMT_PART;
    else if (high_nz)
      kind = rot_pkg::AMT_FULL;
    else
      kind = rot_pkg::AMT_ZERO;
  end
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [LOG_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [LOG_W+1];

  assign stage[0] = din;

  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][SH-1:0], stage[k][DATA_W-1:SH]}
                               : stage[k];
  end

  assign dout = stage[LOG_W];
endmodule

// File: rtl/rot_carry_sel.sv
module rot_carry_sel #(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [LOG_W-1:0]   rot_amt,
  input  rot_pkg::amt_kind_e kind,
  input  logic               cin,
  input  logic               ext,
  output logic               cout
);
  logic [LOG_W-1:0] idx;

  assign idx = rot_amt - LOG_W'(1);

  always_comb begin
    if (ext)
      cout = din[0];
    else begin
      case (kind)
        rot_pkg::AMT_ZERO: cout = cin;
        rot_pkg::AMT_FULL: cout = din[DATA_W-1];
        default:           cout = din[idx];
      endcase
    end
  end
endmodule

// File: rtl/rot_flag_gate.sv
module rot_flag_gate (
  input  logic                     set_flags,
  input  logic [rot_pkg::CLS_W-1:0] op_class,
  output logic                     we
);
  logic class_ok;

  always_comb begin
    case (rot_pkg::op_class_e'(op_class))
      rot_pkg::CLS_ROT, rot_pkg::CLS_MOV, rot_pkg::CLS_MVN,
      rot_pkg::CLS_AND, rot_pkg::CLS_ORR, rot_pkg::CLS_ORN,
      rot_pkg::CLS_EOR, rot_pkg::CLS_BIC, rot_pkg::CLS_TST,
      rot_pkg::CLS_TEQ: class_ok = 1'b1;
      default:          class_ok = 1'b0;
    endcase
  end

  assign we = set_flags & class_ok;
endmodule

// File: rtl/rot_carry_unit.sv
module rot_carry_unit #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DATA_W-1:0]         op_in,
  input  logic [AMT_W-1:0]          amt_in,
  input  logic                      carry_in,
  input  logic                      mode_ext,
  input  logic                      set_flags,
  input  logic [rot_pkg::CLS_W-1:0] op_class,
  output logic [DATA_W-1:0]         result_q,
  output logic                      carry_out,
  output logic                      carry_we
);
  logic [LOG_W-1:0]   rot_amt;
  rot_pkg::amt_kind_e kind;
  logic [DATA_W-1:0]  rot_val;
  logic [DATA_W-1:0]  ext_val;
  logic [DATA_W-1:0]  res_d;
  logic               cout_d;
  logic               we_d;

  rot_amt_reduce #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_reduce (
    .amt     (amt_in),
    .rot_amt (rot_amt),
    .kind    (kind)
  );

  rot_barrel #(.DATA_W(DATA_W)) u_barrel (
    .din  (op_in),
    .amt  (rot_amt),
    .dout (rot_val)
  );

  rot_carry_sel #(.DATA_W(DATA_W)) u_csel (
    .din     (op_in),
    .rot_amt (rot_amt),
    .kind    (kind),
    .cin     (carry_in),
    .ext     (mode_ext),
    .cout    (cout_d)
  );

  rot_flag_gate u_gate (
    .set_flags (set_flags),
    .op_class  (op_class),
    .we        (we_d)
  );

  assign ext_val = {carry_in, op_in[DATA_W-1:1]};
  assign res_d   = mode_ext ? ext_val : rot_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      carry_out <= 1'b0;
      carry_we  <= 1'b0;
    end else begin
      result_q  <= res_d;
      carry_out <= cout_d;
      carry_we  <= we_d;
    end
  end
endmodule

// File: rtl/rot_carry_unit_chk.sv
module rot_carry_unit_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [DATA_W-1:0]         op_in,
  input logic [AMT_W-1:0]          amt_in,
  input logic                      carry_in,
  input logic                      mode_ext,
  input logic                      set_flags,
  input logic [rot_pkg::CLS_W-1:0] op_class,
  input logic [DATA_W-1:0]         result_q,
  input logic                      carry_out,
  input logic                      carry_we
);
  logic full_amt;
  assign full_amt = (amt_in[LOG_W-1:0] == '0) && (amt_in != '0);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result_q == '0 && !carry_out && !carry_we));

  assert_zero_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode_ext && amt_in == '0) |=>
      (result_q == $past(op_in) && carry_out == $past(carry_in)));

  assert_full_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (!mode_ext && full_amt) |=>
      (result_q == $past(op_in) && carry_out == $past(op_in[DATA_W-1])));

  assert_ext_rotate_R6: assert property (@(posedge clk) disable iff (rst)
    mode_ext |=>
      (result_q[DATA_W-2:0] == $past(op_in[DATA_W-1:1]) &&
       result_q[DATA_W-1] == $past(carry_in) &&
       carry_out == $past(op_in[0])));

  assert_arith_no_we_R7: assert property (@(posedge clk) disable iff (rst)
    (op_class >= rot_pkg::CLS_W'(10)) |=> !carry_we);

  assert_no_flags_R8: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> !carry_we);
endmodule

bind rot_carry_unit rot_carry_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_in     (op_in),
  .amt_in    (amt_in),
  .carry_in  (carry_in),
  .mode_ext  (mode_ext),
  .set_flags (set_flags),
  .op_class  (op_class),
  .result_q  (result_q),
  .carry_out (carry_out),
  .carry_we  (carry_we)
);

// File: tb/rot_carry_unit_test.sv
module rot_carry_unit_test;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  op_in = '0;
  logic [AW-1:0] amt_in = '0;
  logic          carry_in = 1'b0;
  logic          mode_ext = 1'b0;
  logic          set_flags = 1'b0;
  logic [3:0]    op_class = '0;
  logic [W-1:0]  result_q;
  logic          carry_out;
  logic          carry_we;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rot_carry_unit #(.DATA_W(W), .AMT_W(AW)) uut (
    .clk(clk), .rst(rst), .op_in(op_in), .amt_in(amt_in),
    .carry_in(carry_in), .mode_ext(mode_ext), .set_flags(set_flags),
    .op_class(op_class), .result_q(result_q), .carry_out(carry_out),
    .carry_we(carry_we)
  );

  // stimulus table: operand, count, carry in, mode, set flags, class
  localparam logic [W-1:0]  V_OP  [NV] = '{32'h8000_0001, 32'h1234_5678,
    32'hDEAD_BEEF, 32'hF000_000F, 32'h0000_0001, 32'h8000_0000,
    32'hA5A5_5A5A, 32'hFFFF_FFFE, 32'h0F0F_0F0F, 32'h1357_9BDF,
    32'h8000_0001, 32'h0000_0002};
  localparam logic [AW-1:0] V_AMT [NV] = '{8'd1, 8'd4, 8'd31, 8'd0,
    8'd32, 8'd33, 8'd64, 8'd200, 8'd255, 8'd17, 8'd9, 8'd96};
  localparam logic          V_CIN [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic          V_EXT [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic          V_SF  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [3:0]    V_CLS [NV] = '{4'd0, 4'd3, 4'd1, 4'd9, 4'd12,
    4'd6, 4'd8, 4'd2, 4'd7, 4'd4, 4'd11, 4'd5};

  function automatic logic [W:0] model(input logic [W-1:0] op,
      input int amt, input logic cin, input logic ext);
    int r;
    logic [W-1:0] v;
    if (ext) return {op[0], cin, op[W-1:1]};
    r = amt;
    while (r > W) r = r - W;
    if (r == 0) return {cin, op};
    v = op;
    for (int i = 0; i < r; i++) v = {v[0], v[W-1:1]};
    return {op[r-1], v};
  endfunction

  function automatic logic model_we(input logic sf, input logic [3:0] cls);
    return sf && (cls <= 4'd9);
  endfunction

  task automatic check(input string req, input string what,
      input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] op, input logic [AW-1:0] amt,
      input logic cin, input logic ext, input logic sf, input logic [3:0] cls);
    @(negedge clk);
    op_in = op; amt_in = amt; carry_in = cin; mode_ext = ext;
    set_flags = sf; op_class = cls;
    @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic [W-1:0] op,
      input logic [AW-1:0] amt, input logic cin, input logic ext,
      input logic sf, input logic [3:0] cls);
    logic [W:0] e;
    apply(op, amt, cin, ext, sf, cls);
    e = model(op, int'(amt), cin, ext);
    check(req, "result", result_q, e[W-1:0]);
    check(req, "carry", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, e[W]});
    check(req, "we", {{(W-1){1'b0}}, carry_we},
          {{(W-1){1'b0}}, model_we(sf, cls)});
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W:0] e32, e0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "reset result", result_q, '0);
    check("R1", "reset carry", {31'b0, carry_out}, '0);
    check("R1", "reset we", {31'b0, carry_we}, '0);
    rst = 1'b0;

    // table walk covering R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++)
      check_all("R2_R6_table", V_OP[i], V_AMT[i], V_CIN[i], V_EXT[i],
                V_SF[i], V_CLS[i]);

    // R3: zero count keeps carry in both polarities
    check_all("R3", 32'hCAFE_F00D, 8'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check_all("R3", 32'hCAFE_F00D, 8'd0, 1'b1, 1'b0, 1'b1, 4'd0);

    // R4: every nonzero multiple of 32
    for (int m = 1; m < 8; m++)
      check_all("R4", 32'h8765_4320, AW'(m * 32), 1'b0, 1'b0, 1'b1, 4'd1);

    // R2 and R5: full count sweep
    for (int a = 0; a < 256; a++)
      check_all((a > 32) ? "R5" : "R2", 32'h9C3A_61E5, AW'(a), a[0], 1'b0,
                1'b1, 4'd0);

    // R5: explicit equivalence of count and count-32
    apply(32'h0123_4567, 8'd45, 1'b0, 1'b0, 1'b1, 4'd0);
    e0 = {carry_out, result_q};
    apply(32'h0123_4567, 8'd13, 1'b0, 1'b0, 1'b1, 4'd0);
    e32 = {carry_out, result_q};
    check("R5", "45 vs 13", e0[W-1:0], e32[W-1:0]);

    // R6: count ignored in extended mode
    for (int a = 0; a < 256; a += 37)
      check_all("R6", 32'h6000_0003, AW'(a), 1'b1, 1'b1, 1'b1, 4'd0);

    // R7 and R8: class sweep with flags on and off, both modes
    for (int c = 0; c < 16; c++) begin
      check_all("R7", 32'h0000_00F1, 8'd3, 1'b0, c[0], 1'b1, 4'(c));
      check_all("R8", 32'h0000_00F1, 8'd3, 1'b0, c[0], 1'b0, 4'(c));
    end

    // R1: reset mid-run clears outputs after one edge
    apply(32'hFFFF_FFFF, 8'd0, 1'b1, 1'b0, 1'b1, 4'd0);
    check("R1", "pre-reset result", result_q, 32'hFFFF_FFFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", "mid reset result", result_q, '0);
    check("R1", "mid reset we", {31'b0, carry_we}, '0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule